// File: doc/BRIEF.md
# 8-bit ALU with processor status flags

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle it may accept one operation: a 4-bit operation code, a register operand (accumulator or index register, chosen by the caller), a memory operand, and the incoming carry, overflow and decimal flags. One clock later it presents the result, fresh negative (N), zero (Z), carry (C) and overflow (V) flags, a write-enable that says whether the result is meant to go back to a register or memory, and an error strobe.

The flag rules follow the classic 8-bit convention. Carry acts as "not borrow" on subtraction and compare. The bit test copies the top two bits of the memory operand into N and V. Rotates pass through the carry. Decimal-mode arithmetic is not implemented: an add or subtract issued while the decimal flag is set raises the error strobe, and nothing is written back. Register files and memory sequencing stay with the caller. Shifts, rotates, increment and decrement always act on the register operand, so the caller routes a memory byte onto that port for the memory forms.

Operation codes: 0 add with carry, 1 subtract with borrow, 2 AND, 3 OR, 4 XOR, 5 compare, 6 bit test, 7 shift left, 8 shift right, 9 rotate left, 10 rotate right, 11 increment, 12 decrement. Codes 13 to 15 are unused.

Top module: `flag_alu`

## Requirements
- R1: While reset (`rstN` low) is applied and afterwards while no operation is in flight, `outValid`, `resultWe` and `decError` are 0.
- R2: `outValid` is high exactly one cycle after `inValid`, and the other outputs belong to that operation.
- R3: Add (code 0) gives result = (reg + mem + C) mod 256. C is set when the unsigned sum exceeds 255. V is set when the signed sum lies outside -128..127. The result is written.
- R4: Subtract (code 1) gives result = (reg - mem - (1 - C)) mod 256. C is set when the unsigned difference is not negative. V is set when the signed difference lies outside -128..127. The result is written.
- R5: Compare (code 5) sets C when reg >= mem (unsigned) and takes N and Z from the low 8 bits of reg - mem. It leaves V as it came in, and `resultWe` is 0.
- R6: Bit test (code 6) sets N from mem bit 7, V from mem bit 6, and Z when reg AND mem is 0. It leaves C as it came in, and `resultWe` is 0.
- R7: Rotate left (code 9) moves C into bit 0 and bit 7 into C. Rotate right (code 10) moves C into bit 7 and bit 0 into C. V passes through and the result is written.
- R8: Shift left (code 7) puts 0 in bit 0 and bit 7 into C. Shift right (code 8) puts 0 in bit 7 and bit 0 into C. V passes through and the result is written.
- R9: Increment (code 11) and decrement (code 12) wrap modulo 256, leave C and V as they came in, and write the result.
- R10: AND, OR and XOR (codes 2, 3, 4) write reg op mem and leave C and V as they came in.
- R11: Add or subtract with the decimal input set raises `decError`, writes nothing, gives result = reg, and leaves C and V as they came in. The decimal input has no effect on any other code.
- R12: Whenever the result is written, Z is 1 exactly when the result is 0 and N equals result bit 7.
- R13: Codes 13 to 15 write nothing, raise no error, give result = reg with N and Z taken from it, and leave C and V as they came in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code |
| regVal | input | 8 | Register operand |
| memVal | input | 8 | Memory operand |
| carryIn | input | 1 | Incoming carry flag |
| overflowIn | input | 1 | Incoming overflow flag |
| decIn | input | 1 | Incoming decimal-mode flag |
| outValid | output | 1 | Outputs hold a completed operation |
| result | output | 8 | Operation result |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |
| resultWe | output | 1 | Result is to be written back |
| decError | output | 1 | Decimal arithmetic was requested |

## Verification
The assertions assume that `inValid` stays low during reset and that operands and flags are stable and known in the cycle `inValid` is high. Each property relates one cycle's inputs to the next cycle's outputs, so the checks also assume nothing else drives the operand ports in between. The stimulus changes inputs only on the falling edge, keeps `inValid` low through reset, and uses a deterministic generator over all sixteen codes with every flag combination. This includes the decimal flag on codes where it must be ignored, as well as the unused codes.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int OP_W = 4;
  typedef logic [OP_W-1:0] opcode_t;

  localparam opcode_t OP_ADDC = 4'd0;
  localparam opcode_t OP_SUBB = 4'd1;
  localparam opcode_t OP_AND  = 4'd2;
  localparam opcode_t OP_OR   = 4'd3;
  localparam opcode_t OP_XOR  = 4'd4;
  localparam opcode_t OP_CMP  = 4'd5;
  localparam opcode_t OP_BTST = 4'd6;
  localparam opcode_t OP_SHL  = 4'd7;
  localparam opcode_t OP_SHR  = 4'd8;
  localparam opcode_t OP_ROTL = 4'd9;
  localparam opcode_t OP_ROTR = 4'd10;
  localparam opcode_t OP_INCR = 4'd11;
  localparam opcode_t OP_DECR = 4'd12;

  typedef enum logic [2:0] {
    UNIT_ADD, UNIT_LOGIC, UNIT_SHIFT, UNIT_BTST, UNIT_HOLD
  } unit_e;

  typedef enum logic [1:0] {
    B_MEM, B_MEM_INV, B_ONE, B_ONES
  } bsel_e;

  typedef enum logic [1:0] {
    CIN_FLAG, CIN_ONE, CIN_ZERO
  } cinsel_e;

  typedef enum logic [1:0] {
    LOG_AND, LOG_OR, LOG_XOR
  } logic_e;

  // control-to-datapath strobes
  typedef struct packed {
    unit_e   unit;
    bsel_e   bSel;
    cinsel_e cinSel;
    logic_e  logicOp;
    logic    shiftLeft;
    logic    shiftThruC;
    logic    wrEn;
    logic    updC;
    logic    updV;
    logic    decErr;
  } strobe_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  opcode_t opCode,
  input  logic    decIn,
  output strobe_t strobes
);

  always_comb begin
    strobes = '{unit: UNIT_HOLD, bSel: B_MEM, cinSel: CIN_FLAG,
                logicOp: LOG_AND, shiftLeft: 1'b0, shiftThruC: 1'b0,
                wrEn: 1'b0, updC: 1'b0, updV: 1'b0, decErr: 1'b0};
    case (opCode)
      OP_ADDC, OP_SUBB: begin
        if (decIn) begin
          strobes.decErr = 1'b1;
        end else begin
          strobes.unit = UNIT_ADD;
          strobes.bSel = (opCode == OP_SUBB) ? B_MEM_INV : B_MEM;
          strobes.wrEn = 1'b1;
          strobes.updC = 1'b1;
          strobes.updV = 1'b1;
        end
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobes.unit = UNIT_LOGIC;
        strobes.wrEn = 1'b1;
        strobes.logicOp = (opCode == OP_AND) ? LOG_AND :
                          (opCode == OP_OR)  ? LOG_OR  : LOG_XOR;
      end
      OP_CMP: begin
        strobes.unit   = UNIT_ADD;
        strobes.bSel   = B_MEM_INV;
        strobes.cinSel = CIN_ONE;
        strobes.updC   = 1'b1;
      end
      OP_BTST: begin
        strobes.unit = UNIT_BTST;
        strobes.updV = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
        strobes.unit       = UNIT_SHIFT;
        strobes.shiftLeft  = (opCode == OP_SHL) || (opCode == OP_ROTL);
        strobes.shiftThruC = (opCode == OP_ROTL) || (opCode == OP_ROTR);
        strobes.wrEn       = 1'b1;
        strobes.updC       = 1'b1;
      end
      OP_INCR, OP_DECR: begin
        strobes.unit   = UNIT_ADD;
        strobes.bSel   = (opCode == OP_INCR) ? B_ONE : B_ONES;
        strobes.cinSel = CIN_ZERO;
        strobes.wrEn   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flag_alu_dpath.sv
module flag_alu_dpath
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] memVal,
  input  logic              carryIn,
  input  logic              overflowIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV,
  output logic              resultWe,
  output logic              decError
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bOp, logicRes, shiftRes, nextRes;
  logic [DATA_W:0]   sum;
  logic cinBit, addV, fillBit, shiftCout;
  logic nextN, nextZ, nextC, nextV;

  always_comb begin
    case (strobes.bSel)
      B_MEM:     bOp = memVal;
      B_MEM_INV: bOp = ~memVal;
      B_ONE:     bOp = DATA_W'(1);
      default:   bOp = '1;
    endcase
    case (strobes.cinSel)
      CIN_FLAG: cinBit = carryIn;
      CIN_ONE:  cinBit = 1'b1;
      default:  cinBit = 1'b0;
    endcase
    sum  = {1'b0, regVal} + {1'b0, bOp} + {{DATA_W{1'b0}}, cinBit};
    addV = (regVal[MSB] == bOp[MSB]) && (sum[MSB] != regVal[MSB]);
  end

  always_comb begin
    case (strobes.logicOp)
      LOG_AND: logicRes = regVal & memVal;
      LOG_OR:  logicRes = regVal | memVal;
      default: logicRes = regVal ^ memVal;
    endcase
  end

  always_comb begin
    fillBit = strobes.shiftThruC & carryIn;
    if (strobes.shiftLeft) begin
      shiftRes  = {regVal[MSB-1:0], fillBit};
      shiftCout = regVal[MSB];
    end else begin
      shiftRes  = {fillBit, regVal[MSB:1]};
      shiftCout = regVal[0];
    end
  end

  always_comb begin
    case (strobes.unit)
      UNIT_ADD:   nextRes = sum[DATA_W-1:0];
      UNIT_LOGIC: nextRes = logicRes;
      UNIT_SHIFT: nextRes = shiftRes;
      UNIT_BTST:  nextRes = regVal & memVal;
      default:    nextRes = regVal;
    endcase
    nextZ = (nextRes == '0);
    nextN = (strobes.unit == UNIT_BTST) ? memVal[MSB] : nextRes[MSB];
    if (!strobes.updC)                   nextC = carryIn;
    else if (strobes.unit == UNIT_SHIFT) nextC = shiftCout;
    else                                 nextC = sum[DATA_W];
    if (!strobes.updV)                   nextV = overflowIn;
    else if (strobes.unit == UNIT_BTST)  nextV = memVal[MSB-1];
    else                                 nextV = addV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      resultWe <= 1'b0;
      decError <= 1'b0;
      result   <= '0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagC    <= 1'b0;
      flagV    <= 1'b0;
    end else begin
      outValid <= inValid;
      resultWe <= inValid & strobes.wrEn;
      decError <= inValid & strobes.decErr;
      if (inValid) begin
        result <= nextRes;
        flagN  <= nextN;
        flagZ  <= nextZ;
        flagC  <= nextC;
        flagV  <= nextV;
      end
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] memVal,
  input  logic              carryIn,
  input  logic              overflowIn,
  input  logic              decIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV,
  output logic              resultWe,
  output logic              decError
);

  strobe_t strobes;

  flag_alu_ctrl u_ctrl (
    .opCode  (opCode),
    .decIn   (decIn),
    .strobes (strobes)
  );

  flag_alu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .strobes    (strobes),
    .regVal     (regVal),
    .memVal     (memVal),
    .carryIn    (carryIn),
    .overflowIn (overflowIn),
    .outValid   (outValid),
    .result     (result),
    .flagN      (flagN),
    .flagZ      (flagZ),
    .flagC      (flagC),
    .flagV      (flagV),
    .resultWe   (resultWe),
    .decError   (decError)
  );

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] regVal,
  input logic [DATA_W-1:0] memVal,
  input logic              carryIn,
  input logic              overflowIn,
  input logic              decIn,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagC,
  input logic              flagV,
  input logic              resultWe,
  input logic              decError
);

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!resultWe && !decError));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  assert_compare_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == OP_CMP) |=>
      (!resultWe && flagC == ($past(regVal) >= $past(memVal))
       && flagV == $past(overflowIn)));

  assert_bittest_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == OP_BTST) |=>
      (!resultWe && flagN == $past(memVal[DATA_W-1])
       && flagV == $past(memVal[DATA_W-2]) && flagC == $past(carryIn)));

  assert_incdec_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opCode == OP_INCR || opCode == OP_DECR)) |=>
      (resultWe && flagC == $past(carryIn) && flagV == $past(overflowIn)));

  assert_logic_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR)) |=>
      (resultWe && flagC == $past(carryIn) && flagV == $past(overflowIn)));

  assert_decerr_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && decIn && (opCode == OP_ADDC || opCode == OP_SUBB)) |=>
      (decError && !resultWe && result == $past(regVal)
       && flagC == $past(carryIn)));

  assert_nz_R12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && resultWe) |->
      (flagZ == (result == '0) && flagN == result[DATA_W-1]));

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
  .regVal(regVal), .memVal(memVal), .carryIn(carryIn),
  .overflowIn(overflowIn), .decIn(decIn), .outValid(outValid),
  .result(result), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
  .flagV(flagV), .resultWe(resultWe), .decError(decError)
);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;

  typedef struct {
    logic [7:0] res;
    bit n, z, c, v, we, err;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] regVal = '0, memVal = '0;
  logic carryIn = 1'b0, overflowIn = 1'b0, decIn = 1'b0;
  logic outValid, flagN, flagZ, flagC, flagV, resultWe, decError;
  logic [7:0] result;

  int total = 0;
  int bad = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  flag_alu u_flag_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .regVal(regVal), .memVal(memVal), .carryIn(carryIn),
    .overflowIn(overflowIn), .decIn(decIn), .outValid(outValid),
    .result(result), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
    .flagV(flagV), .resultWe(resultWe), .decError(decError)
  );

  function automatic int sgn(input logic [7:0] x);
    return x[7] ? int'(x) - 256 : int'(x);
  endfunction

  function automatic exp_t model(input int op, input logic [7:0] a,
                                 input logic [7:0] m, input bit c,
                                 input bit v, input bit d);
    exp_t e;
    int s, sv;
    e.c = c; e.v = v; e.we = 1; e.err = 0; e.res = a;
    case (op)
      0: begin
        e.tag = "R3";
        if (d) begin e.tag = "R11"; e.we = 0; e.err = 1; end
        else begin
          s = int'(a) + int'(m) + int'(c); sv = sgn(a) + sgn(m) + int'(c);
          e.res = s[7:0]; e.c = s > 255; e.v = (sv > 127) || (sv < -128);
        end
      end
      1: begin
        e.tag = "R4";
        if (d) begin e.tag = "R11"; e.we = 0; e.err = 1; end
        else begin
          s = int'(a) - int'(m) - (1 - int'(c)); sv = sgn(a) - sgn(m) - (1 - int'(c));
          e.res = s[7:0]; e.c = s >= 0; e.v = (sv > 127) || (sv < -128);
        end
      end
      2: begin e.tag = "R10"; e.res = a & m; end
      3: begin e.tag = "R10"; e.res = a | m; end
      4: begin e.tag = "R10"; e.res = a ^ m; end
      5: begin
        e.tag = "R5"; s = int'(a) - int'(m);
        e.res = s[7:0]; e.c = s >= 0; e.we = 0;
      end
      6: begin e.tag = "R6"; e.res = a & m; e.we = 0; e.v = m[6]; end
      7: begin e.tag = "R8"; e.res = {a[6:0], 1'b0}; e.c = a[7]; end
      8: begin e.tag = "R8"; e.res = {1'b0, a[7:1]}; e.c = a[0]; end
      9: begin e.tag = "R7"; e.res = {a[6:0], c}; e.c = a[7]; end
      10: begin e.tag = "R7"; e.res = {c, a[7:1]}; e.c = a[0]; end
      11: begin e.tag = "R9"; e.res = a + 8'd1; end
      12: begin e.tag = "R9"; e.res = a - 8'd1; end
      default: begin e.tag = "R13"; e.we = 0; end
    endcase
    e.z = (e.res == 8'h00);
    e.n = (op == 6) ? m[7] : e.res[7];
    return e;
  endfunction

  task automatic drive(input int op, input logic [7:0] a, input logic [7:0] m,
                       input bit c, input bit v, input bit d);
    @(negedge clk);
    opCode = 4'(op); regVal = a; memVal = m;
    carryIn = c; overflowIn = v; decIn = d; inValid = 1'b1;
    sb.push_back(model(op, a, m, c, v, d));
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor: outputs of the previous edge, compared against the queue head
  always @(negedge clk) begin
    if (rstN && outValid) begin
      exp_t e;
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R2: unexpected outValid, got 1 exp 0");
      end else begin
        e = sb.pop_front();
        if (result !== e.res || flagN !== e.n || flagZ !== e.z ||
            flagC !== e.c || flagV !== e.v || resultWe !== e.we ||
            decError !== e.err) begin
          bad++;
          $display("FAIL %s: got res=%h N%b Z%b C%b V%b we%b err%b exp res=%h N%b Z%b C%b V%b we%b err%b",
                   e.tag, result, flagN, flagZ, flagC, flagV, resultWe, decError,
                   e.res, e.n, e.z, e.c, e.v, e.we, e.err);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    repeat (4) @(negedge clk);
    // R1: quiet outputs during reset
    total++;
    if (outValid !== 1'b0 || resultWe !== 1'b0 || decError !== 1'b0) begin
      bad++;
      $display("FAIL R1: got v%b we%b err%b exp 000", outValid, resultWe, decError);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    total++;
    if (outValid !== 1'b0 || resultWe !== 1'b0 || decError !== 1'b0) begin
      bad++;
      $display("FAIL R1: got v%b we%b err%b exp 000 after reset", outValid, resultWe, decError);
    end

    // R3 add corners
    drive(0, 8'h50, 8'h50, 0, 0, 0);
    drive(0, 8'hFF, 8'h01, 0, 0, 0);
    drive(0, 8'h7F, 8'h00, 1, 0, 0);
    drive(0, 8'h80, 8'h80, 0, 0, 0);
    // R4 subtract corners
    drive(1, 8'h00, 8'h01, 1, 0, 0);
    drive(1, 8'h80, 8'h01, 1, 0, 0);
    drive(1, 8'h50, 8'hF0, 1, 0, 0);
    drive(1, 8'h05, 8'h05, 0, 1, 0);
    // R5 compare: equal, less, greater
    drive(5, 8'h42, 8'h42, 0, 1, 0);
    drive(5, 8'h10, 8'h20, 1, 0, 0);
    drive(5, 8'hF0, 8'h01, 0, 0, 0);
    // R6 bit test
    drive(6, 8'h0F, 8'hC0, 1, 0, 0);
    drive(6, 8'h01, 8'h41, 0, 1, 0);
    // R7 rotates through carry
    drive(9, 8'h80, 8'h00, 1, 1, 0);
    drive(10, 8'h01, 8'h00, 0, 0, 0);
    drive(10, 8'h02, 8'h00, 1, 0, 0);
    // R8 shifts
    drive(7, 8'h80, 8'h00, 0, 0, 0);
    drive(8, 8'h01, 8'h00, 1, 1, 0);
    drive(8, 8'hFE, 8'h00, 0, 0, 0);
    idle();
    // R9 wrap, R10 logic keeps C and V
    drive(11, 8'hFF, 8'h00, 1, 1, 0);
    drive(12, 8'h00, 8'h00, 0, 1, 0);
    drive(2, 8'hF0, 8'h0F, 1, 1, 0);
    drive(3, 8'h00, 8'h00, 0, 1, 0);
    drive(4, 8'hAA, 8'h55, 1, 0, 0);
    // R11 decimal error, and ignored elsewhere
    drive(0, 8'h12, 8'h34, 1, 0, 1);
    drive(1, 8'h00, 8'h34, 0, 1, 1);
    drive(2, 8'hFF, 8'h81, 1, 0, 1);
    drive(11, 8'h7F, 8'h00, 0, 0, 1);
    // R13 unused codes
    drive(13, 8'h00, 8'hFF, 1, 1, 0);
    drive(15, 8'h9C, 8'h00, 0, 1, 1);
    idle();
    // deterministic sweep, R12 on every written result
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(int'(lfsr[3:0]), lfsr[11:4], lfsr[19:12], lfsr[20], lfsr[21],
            lfsr[24:22] == 3'b000);
      if (lfsr[27:25] == 3'b111) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R2: got %0d pending exp 0", sb.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule